// File: doc/BRIEF.md
# Dual-Bus DSP Address Generator

This block supplies two data-memory addresses in the same cycle for a DSP core that moves one X operand and one Y operand per cycle. The X side has two pointer registers and one index register. The Y side has its own two pointers and its own index. On each active side, a decoded command picks one of that side's pointers and an update mode. The block drives the pointer's present value onto the side's address output. It then updates that pointer after the access: it leaves it alone, adds two, or adds the side's index register.

Each side has a dedicated adder, so both sides can post-update in the same cycle. To walk a pointer downward, load a two's-complement negative value into the index and use the index-add mode. A small register-file port loads and reads all six registers. A write on that port takes priority over a post-update of the same pointer in the same cycle.

Top module: `xy_addr_gen`

## Requirements
- R1: While reset is asserted (rstN low, asynchronous), all six registers read as 0, and the address outputs are 0 on both the enabled and the disabled path.
- R2: When a side is enabled, its address output shows the selected pointer's value before any update (sel 0 or 1 picks the first or second pointer of that side).
- R3: Mode 2'b01 adds 2 to the selected pointer at the clock edge that ends the access.
- R4: Mode 2'b10 adds the side's index register to the selected pointer. A negative index moves the pointer downward.
- R5: Modes 2'b00 and 2'b11 leave the selected pointer unchanged.
- R6: The X and Y sides update their pointers in the same cycle, each by its own mode and index.
- R7: When a side's enable is low, that side's address output keeps the last address it issued, and none of that side's pointers change.
- R8: A register-file write to a pointer in the same cycle as that pointer's post-update wins. The pointer takes the written data.
- R9: Register-file map: 0 = X pointer 0, 1 = X pointer 1, 2 = Y pointer 0, 3 = Y pointer 1, 4 = X index, 5 = Y index. A write takes effect at the next edge. A read is combinational. Writes to 6 and 7 are ignored, and reads of 6 and 7 return 0.
- R10: Pointer additions wrap modulo 2^32.
- R11: Only the selected pointer of a side updates. The other pointer of that side keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xEn | input | 1 | X side active this cycle |
| xSel | input | 1 | X pointer select |
| xMode | input | 2 | X post-update mode |
| yEn | input | 1 | Y side active this cycle |
| ySel | input | 1 | Y pointer select |
| yMode | input | 2 | Y post-update mode |
| rfWe | input | 1 | Register-file write strobe |
| rfWaddr | input | 3 | Register-file write index |
| rfWdata | input | 32 | Register-file write data |
| rfRaddr | input | 3 | Register-file read index |
| rfRdata | output | 32 | Register-file read data |
| xAddr | output | 32 | X data address |
| yAddr | output | 32 | Y data address |

## Verification
The bench walks one pointer downward with a negative index. A design that treated the index as unsigned, or used the post-update value as the address, would produce the wrong sequence. It steps a pointer across the top of the 32-bit range to catch a saturating or widened adder. It disables a side while its mode still requests an update, to expose an address that falls back to the live pointer or a pointer that still moves. It writes a pointer in the same cycle as its own post-update, where a design with the wrong priority would keep the incremented value. It also confirms that writes to the unused register indices change nothing visible.

// File: rtl/xy_agu_pkg.sv
package xy_agu_pkg;

  localparam int NUM_SIDES = 2;
  localparam int PTRS_PER_SIDE = 2;
  localparam int RF_AW = 3;
  localparam int NUM_RF_REGS = NUM_SIDES * PTRS_PER_SIDE + NUM_SIDES;
  localparam int IDX_BASE = NUM_SIDES * PTRS_PER_SIDE;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_STEP  = 2'b01,
    MODE_INDEX = 2'b10,
    MODE_RSVD  = 2'b11
  } upd_mode_e;

  // strobes for one side, decoded by control and consumed by the datapath
  typedef struct packed {
    logic issue;     // side active: drive live pointer and capture it
    logic ptrSel;    // which pointer of the side
    logic bump;      // post-update the selected pointer
    logic useIndex;  // increment comes from the index register
  } side_ctl_t;

  typedef struct packed {
    side_ctl_t [NUM_SIDES-1:0] sides;
    logic [NUM_RF_REGS-1:0]    rfWrStb;
  } agu_ctl_t;

endpackage

// File: rtl/xy_agu_ctrl.sv
module xy_agu_ctrl
  import xy_agu_pkg::*;
(
  input  logic                   xEn,
  input  logic                   xSel,
  input  logic [1:0]             xMode,
  input  logic                   yEn,
  input  logic                   ySel,
  input  logic [1:0]             yMode,
  input  logic                   rfWe,
  input  logic [RF_AW-1:0]       rfWaddr,
  output agu_ctl_t               ctl
);

  logic [NUM_RF_REGS-1:0] wrStb;
  logic [NUM_SIDES-1:0]   sideEn;
  logic [NUM_SIDES-1:0]   sideSel;
  logic [NUM_SIDES-1:0][1:0] sideMode;

  assign sideEn   = {yEn, xEn};
  assign sideSel  = {ySel, xSel};
  assign sideMode = {yMode, xMode};

  // one-hot write strobes; indices beyond the map decode to nothing
  for (genvar r = 0; r < NUM_RF_REGS; r++) begin : g_wr
    assign wrStb[r] = rfWe && (rfWaddr == RF_AW'(r));
  end

  assign ctl.rfWrStb = wrStb;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    upd_mode_e mode;
    logic      ptrHit;
    logic      wantsUpd;

    assign mode     = upd_mode_e'(sideMode[s]);
    assign ptrHit   = sideSel[s] ? wrStb[s*PTRS_PER_SIDE + 1] : wrStb[s*PTRS_PER_SIDE];
    assign wantsUpd = (mode == MODE_STEP) || (mode == MODE_INDEX);

    always_comb begin
      ctl.sides[s].issue    = sideEn[s];
      ctl.sides[s].ptrSel   = sideSel[s];
      // a register-file write to the same pointer overrides the post-update
      ctl.sides[s].bump     = sideEn[s] && wantsUpd && !ptrHit;
      ctl.sides[s].useIndex = (mode == MODE_INDEX);
    end
  end

endmodule

// File: rtl/xy_agu_datapath.sv
module xy_agu_datapath
  import xy_agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  agu_ctl_t                     ctl,
  input  logic [AW-1:0]                rfWdata,
  input  logic [RF_AW-1:0]             rfRaddr,
  output logic [NUM_SIDES-1:0][AW-1:0] sideAddr,
  output logic [AW-1:0]                rfRdata
);

  logic [NUM_SIDES-1:0][AW-1:0] sideRd;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [AW-1:0] ptrQ [PTRS_PER_SIDE];
    logic [AW-1:0] idxQ;
    logic [AW-1:0] holdQ;
    logic [AW-1:0] curPtr;
    logic [AW-1:0] incr;
    logic [AW-1:0] nextPtr;
    side_ctl_t     sc;

    assign sc      = ctl.sides[s];
    assign curPtr  = sc.ptrSel ? ptrQ[1] : ptrQ[0];
    // dedicated per-side adder, wraps at the word width
    assign incr    = sc.useIndex ? idxQ : AW'(STEP);
    assign nextPtr = curPtr + incr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int p = 0; p < PTRS_PER_SIDE; p++) ptrQ[p] <= '0;
        idxQ  <= '0;
        holdQ <= '0;
      end else begin
        for (int p = 0; p < PTRS_PER_SIDE; p++) begin
          if (ctl.rfWrStb[s*PTRS_PER_SIDE + p])
            ptrQ[p] <= rfWdata;
          else if (sc.bump && (sc.ptrSel == p[0]))
            ptrQ[p] <= nextPtr;
        end
        if (ctl.rfWrStb[IDX_BASE + s])
          idxQ <= rfWdata;
        if (sc.issue)
          holdQ <= curPtr;
      end
    end

    assign sideAddr[s] = sc.issue ? curPtr : holdQ;

    always_comb begin
      sideRd[s] = '0;
      if (rfRaddr == RF_AW'(s*PTRS_PER_SIDE))
        sideRd[s] = ptrQ[0];
      else if (rfRaddr == RF_AW'(s*PTRS_PER_SIDE + 1))
        sideRd[s] = ptrQ[1];
      else if (rfRaddr == RF_AW'(IDX_BASE + s))
        sideRd[s] = idxQ;
    end
  end

  always_comb begin
    rfRdata = '0;
    for (int s = 0; s < NUM_SIDES; s++) rfRdata = rfRdata | sideRd[s];
  end

endmodule

// File: rtl/xy_addr_gen.sv
module xy_addr_gen
  import xy_agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xEn,
  input  logic             xSel,
  input  logic [1:0]       xMode,
  input  logic             yEn,
  input  logic             ySel,
  input  logic [1:0]       yMode,
  input  logic             rfWe,
  input  logic [RF_AW-1:0] rfWaddr,
  input  logic [AW-1:0]    rfWdata,
  input  logic [RF_AW-1:0] rfRaddr,
  output logic [AW-1:0]    rfRdata,
  output logic [AW-1:0]    xAddr,
  output logic [AW-1:0]    yAddr
);

  agu_ctl_t                     ctl;
  logic [NUM_SIDES-1:0][AW-1:0] sideAddr;

  xy_agu_ctrl u_ctrl (
    .xEn     (xEn),
    .xSel    (xSel),
    .xMode   (xMode),
    .yEn     (yEn),
    .ySel    (ySel),
    .yMode   (yMode),
    .rfWe    (rfWe),
    .rfWaddr (rfWaddr),
    .ctl     (ctl)
  );

  xy_agu_datapath #(.AW(AW), .STEP(STEP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rfWdata  (rfWdata),
    .rfRaddr  (rfRaddr),
    .sideAddr (sideAddr),
    .rfRdata  (rfRdata)
  );

  assign xAddr = sideAddr[0];
  assign yAddr = sideAddr[1];

endmodule

// File: rtl/xy_addr_gen_chk.sv
module xy_addr_gen_chk #(
  parameter int AW   = 32,
  parameter int STEP = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          xEn,
  input logic          xSel,
  input logic [1:0]    xMode,
  input logic          yEn,
  input logic          ySel,
  input logic [1:0]    yMode,
  input logic          rfWe,
  input logic [2:0]    rfWaddr,
  input logic [AW-1:0] rfWdata,
  input logic [2:0]    rfRaddr,
  input logic [AW-1:0] rfRdata,
  input logic [AW-1:0] xAddr,
  input logic [AW-1:0] yAddr
);

  logic live;
  logic xHit;
  logic yHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  assign xHit = rfWe && (rfWaddr == {2'b00, xSel});
  assign yHit = rfWe && (rfWaddr == {2'b01, ySel});

  assert_hold_x_R7: assert property (@(posedge clk) disable iff (!rstN)
    live && !xEn && $past(!xEn) |-> $stable(xAddr));

  assert_hold_y_R7: assert property (@(posedge clk) disable iff (!rstN)
    live && !yEn && $past(!yEn) |-> $stable(yAddr));

  assert_step_x_R3: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(xEn && xMode == 2'b01 && !xHit) && xEn && (xSel == $past(xSel))
    |-> xAddr == $past(xAddr) + AW'(STEP));

  assert_step_y_R3: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(yEn && yMode == 2'b01 && !yHit) && yEn && (ySel == $past(ySel))
    |-> yAddr == $past(yAddr) + AW'(STEP));

  assert_keep_x_R5: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(xEn && (xMode == 2'b00 || xMode == 2'b11) && !xHit)
    && xEn && (xSel == $past(xSel)) |-> $stable(xAddr));

  assert_rfwin_x_R8: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(xEn && xMode != 2'b00 && xHit) && xEn && (xSel == $past(xSel))
    |-> xAddr == $past(rfWdata));

  assert_unused_rd_R9: assert property (@(posedge clk) disable iff (!rstN)
    rfRaddr >= 3'd6 |-> rfRdata == '0);

endmodule

bind xy_addr_gen xy_addr_gen_chk #(.AW(AW), .STEP(STEP)) u_chk (.*);

// File: tb/sim_xy_addr_gen.sv
module sim_xy_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xEn = 0, xSel = 0, yEn = 0, ySel = 0, rfWe = 0;
  logic [1:0]  xMode = 0, yMode = 0;
  logic [2:0]  rfWaddr = 0, rfRaddr = 0;
  logic [31:0] rfWdata = 0;
  logic [31:0] rfRdata, xAddr, yAddr;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  xy_addr_gen u0 (
    .clk(clk), .rstN(rstN),
    .xEn(xEn), .xSel(xSel), .xMode(xMode),
    .yEn(yEn), .ySel(ySel), .yMode(yMode),
    .rfWe(rfWe), .rfWaddr(rfWaddr), .rfWdata(rfWdata),
    .rfRaddr(rfRaddr), .rfRdata(rfRdata),
    .xAddr(xAddr), .yAddr(yAddr)
  );

  typedef struct packed {
    logic        xEn;
    logic        xSel;
    logic [1:0]  xMode;
    logic        yEn;
    logic        ySel;
    logic [1:0]  yMode;
    logic        rfWe;
    logic [2:0]  rfWaddr;
    logic [31:0] rfWdata;
    logic [2:0]  rfRaddr;
    logic [31:0] expX;
    logic [31:0] expY;
    logic [31:0] expRd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R9 load X ptr0; R7 both sides idle, outputs held at 0
    '{1'b0,1'b0,2'b00, 1'b0,1'b0,2'b00, 1'b1,3'd0,32'h0000_1000, 3'd0, 32'h0,        32'h0,        32'h0,         4'd9},
    // R2 R3 issue X ptr0 then +2
    '{1'b1,1'b0,2'b01, 1'b0,1'b0,2'b00, 1'b1,3'd1,32'h0000_2000, 3'd0, 32'h0000_1000,32'h0,        32'h0000_1000, 4'd2},
    '{1'b1,1'b0,2'b01, 1'b0,1'b0,2'b00, 1'b1,3'd4,32'hFFFF_FFFC, 3'd1, 32'h0000_1002,32'h0,        32'h0000_2000, 4'd3},
    // R4 negative X index walks ptr1 down
    '{1'b1,1'b1,2'b10, 1'b0,1'b0,2'b00, 1'b1,3'd2,32'h0000_8000, 3'd4, 32'h0000_2000,32'h0,        32'hFFFF_FFFC, 4'd4},
    // R6 both sides update in one cycle
    '{1'b1,1'b1,2'b10, 1'b1,1'b0,2'b01, 1'b1,3'd5,32'h0000_0010, 3'd2, 32'h0000_1FFC,32'h0000_8000,32'h0000_8000, 4'd6},
    // R5 mode 00 keeps X; R4 Y index add
    '{1'b1,1'b1,2'b00, 1'b1,1'b0,2'b10, 1'b0,3'd0,32'h0,         3'd5, 32'h0000_1FF8,32'h0000_8002,32'h0000_0010, 4'd5},
    // R5 reserved mode 11 keeps X
    '{1'b1,1'b1,2'b11, 1'b1,1'b0,2'b10, 1'b0,3'd0,32'h0,         3'd1, 32'h0000_1FF8,32'h0000_8012,32'h0000_1FF8, 4'd5},
    // R7 disabled sides hold; R11 X ptr0 untouched by ptr1 traffic
    '{1'b0,1'b0,2'b01, 1'b0,1'b0,2'b00, 1'b0,3'd0,32'h0,         3'd0, 32'h0000_1FF8,32'h0000_8012,32'h0000_1004, 4'd7},
    // R8 write to X ptr0 during its +2
    '{1'b1,1'b0,2'b01, 1'b1,1'b1,2'b01, 1'b1,3'd0,32'h0000_5000, 3'd2, 32'h0000_1004,32'h0,        32'h0000_8022, 4'd8},
    '{1'b1,1'b0,2'b00, 1'b1,1'b1,2'b00, 1'b0,3'd0,32'h0,         3'd3, 32'h0000_5000,32'h0000_0002,32'h0000_0002, 4'd8},
    // R9 write to unused index 6 ignored, read 0
    '{1'b1,1'b0,2'b00, 1'b0,1'b0,2'b00, 1'b1,3'd6,32'h0000_DEAD, 3'd6, 32'h0000_5000,32'h0000_0002,32'h0,         4'd9},
    '{1'b1,1'b0,2'b00, 1'b0,1'b0,2'b00, 1'b1,3'd1,32'hFFFF_FFFF, 3'd7, 32'h0000_5000,32'h0000_0002,32'h0,         4'd9},
    // R10 +2 wraps past the top of the range
    '{1'b1,1'b1,2'b01, 1'b1,1'b0,2'b00, 1'b0,3'd0,32'h0,         3'd6, 32'hFFFF_FFFF,32'h0000_8022,32'h0,         4'd10},
    '{1'b1,1'b1,2'b00, 1'b1,1'b0,2'b00, 1'b0,3'd0,32'h0,         3'd1, 32'h0000_0001,32'h0000_8022,32'h0000_0001, 4'd10}
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    xEn = v.xEn; xSel = v.xSel; xMode = v.xMode;
    yEn = v.yEn; ySel = v.ySel; yMode = v.yMode;
    rfWe = v.rfWe; rfWaddr = v.rfWaddr; rfWdata = v.rfWdata;
    rfRaddr = v.rfRaddr;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog run hung actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state, enabled side sees pointer 0
    @(negedge clk);
    xEn = 1'b1; yEn = 1'b0;
    #2;
    check("reset xAddr enabled", 1, xAddr, 32'h0);
    check("reset yAddr held", 1, yAddr, 32'h0);
    for (int r = 0; r < 8; r++) begin
      rfRaddr = 3'(r);
      #1;
      check($sformatf("reset reg %0d", r), 1, rfRdata, 32'h0);
    end
    xEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #2;
      check($sformatf("vec %0d xAddr", i), int'(TBL[i].req), xAddr, TBL[i].expX);
      check($sformatf("vec %0d yAddr", i), int'(TBL[i].req), yAddr, TBL[i].expY);
      check($sformatf("vec %0d rfRdata", i), int'(TBL[i].req), rfRdata, TBL[i].expRd);
    end

    // R1 asynchronous reset mid-run clears every register and the held addresses
    @(negedge clk);
    xEn = 0; yEn = 0; rfWe = 0;
    rstN = 1'b0;
    #2;
    check("async reset xAddr", 1, xAddr, 32'h0);
    check("async reset yAddr", 1, yAddr, 32'h0);
    for (int r = 0; r < 6; r++) begin
      rfRaddr = 3'(r);
      #1;
      check($sformatf("async reset reg %0d", r), 1, rfRdata, 32'h0);
    end
    @(negedge clk);
    rstN = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule